// File: doc/BRIEF.md
# Debounced Edge-Interrupt Input Port

The block watches eight general-purpose input pins and turns qualified level changes on them into interrupt requests. Each pin is first brought into the clock domain by a two-stage synchronizer. It then passes through a level-check filter. The filter only accepts a new level after the pin has held that level for a programmable number of slow reference ticks. Inputs 0 to 3 share one filter setting and inputs 4 to 7 share another.

The filtered levels feed an edge detector. A per-pin edge-select bit decides whether a rising or a falling transition counts. A qualifying transition sets a sticky factor flag, and software clears the flag by writing a one to it. The request output is the OR of all flags whose enable bit is set, gated by a 2-bit priority level in which zero means no request. That level is also driven out.

Changing a filter setting while a pin is mid-transition could create a false edge. For this reason, a change of setting holds off flag setting for that group of four pins for the new check time plus two ticks.

Top module: `debounce_irq_port`

## Requirements
- R1: After synchronous reset every register reads 0, all filtered levels are 0, `irq_req` is 0 and `irq_level` is 0.
- R2: Pin samples pass two synchronizer flops. With a group's filter bypassed, a pin change made after clock edge N is visible in the filtered levels after edge N+3.
- R3: The filter setting register is at address 3. Bits [2:0] set the code for inputs 0–3 and bits [6:4] set the code for inputs 4–7. The codes are: 1 = 128 ticks, 2 = 512, 3 = 2048, 4 = 4096, and 0 or 5–7 = bypass. With one tick every cycle, a pin change after edge N reaches the filtered level at edge N+2+L for check length L.
- R4: A pin level that holds for fewer than L ticks leaves the filtered level unchanged, and any return to the filtered level restarts the count.
- R5: The edge-select register is at address 0. Bit i = 0 makes a rising filtered edge on input i set flag i, and bit i = 1 makes a falling edge set it. The flag appears one edge after the filtered level changes.
- R6: The flags are at address 2 and are sticky. Writing 1 to a bit clears it and writing 0 has no effect. A set in the same cycle as a clear wins.
- R7: The enable register is at address 1. Flags set regardless of enable. `irq_req` is high exactly when some flag and its enable bit are both 1 and the priority is not 0.
- R8: The priority is at address 4, bits [1:0]. `irq_level` equals the priority while `irq_req` is high and is 0 otherwise. Priority 0 never requests.
- R9: A write to address 3 that changes a group's code restarts that group's filter counts. It also blocks flag setting in that group for the new L+2 ticks (2 ticks when bypassed). Rewriting the same code has no effect.
- R10: Filter counts and the hold-off count advance only in cycles where `slow_tick` is 1.
- R11: Address 5 returns the filtered levels, read-only. Unused bits of addresses 3 and 4 read 0, and addresses 6 and 7 read 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable marking a period of the slow reference clock |
| pin_in | input | 8 | Raw asynchronous input pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 2 | Priority level of the pending request |

## Verification
Long runs of pseudo-random pin patterns with the filters bypassed check edge direction, flag stickiness and masking against the model every cycle. Pulses shorter than the check time, and levels held exactly L+1 and L+2 edges, separate a correct count length from one that is off by one or restarts wrongly. A pin held while `slow_tick` is low shows that the count depends on ticks and not on cycles. The filter setting is changed in the middle of a transition, and also from filtered to bypass. Both cases show the hold-off suppressing flags that the new setting would otherwise raise.

// File: rtl/dip_pkg.sv
// Package: shared register address map and the filter code to check-length mapping.
// Assumes a 3-bit register address space.
package dip_pkg;

    localparam int ADDR_W = 3;

    typedef logic [2:0] chk_code_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_EDGE  = 3'd0,
        RA_MASK  = 3'd1,
        RA_FLAG  = 3'd2,
        RA_FILT  = 3'd3,
        RA_PRIO  = 3'd4,
        RA_LEVEL = 3'd5
    } reg_addr_e;

    // Map a filter code to its check length in slow ticks (0 = bypass).
    function automatic int unsigned check_len(chk_code_t code, int unsigned l1,
                                              int unsigned l2, int unsigned l3,
                                              int unsigned l4);
        case (code)
            3'd1:    return l1;
            3'd2:    return l2;
            3'd3:    return l3;
            3'd4:    return l4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dip_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent (no multi-bit coherency needed).
module dip_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/dip_filt_grp.sv
// Module: level-check filter for one group of pins sharing a filter code,
// plus the hold-off counter that quiets flag setting after a code change.
// Assumes code_wr pulses in the same cycle the code register takes code_nxt.
module dip_filt_grp
    import dip_pkg::*;
#(
    parameter int          W     = 4,
    parameter int unsigned LEN_A = 128,
    parameter int unsigned LEN_B = 512,
    parameter int unsigned LEN_C = 2048,
    parameter int unsigned LEN_D = 4096,
    parameter int          CW    = $clog2(LEN_D + 3)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] raw,
    input  chk_code_t    code,
    input  logic         code_wr,
    input  chk_code_t    code_nxt,
    output logic [W-1:0] filt,
    output logic         quiet
);
    logic [CW-1:0] lim;
    logic [CW-1:0] lim_nxt;
    logic          bypass;
    logic [CW-1:0] hold_q;

    assign lim     = CW'(check_len(code, LEN_A, LEN_B, LEN_C, LEN_D));
    assign lim_nxt = CW'(check_len(code_nxt, LEN_A, LEN_B, LEN_C, LEN_D));
    assign bypass  = (lim == '0);
    assign quiet   = (hold_q != '0);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic          lvl_q;
        logic [CW-1:0] cnt_q;

        // Count ticks while the pin differs from the accepted level; accept at the limit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q <= 1'b0;
                cnt_q <= '0;
            end else if (code_wr) begin
                cnt_q <= '0;
            end else if (bypass) begin
                lvl_q <= raw[i];
            end else if (raw[i] == lvl_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == lim - 1'b1) begin
                    lvl_q <= raw[i];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        assign filt[i] = lvl_q;

        assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass) |-> (cnt_q < lim));
    end

    // Hold-off: new check length plus two ticks after a code change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (code_wr) begin
            hold_q <= lim_nxt + CW'(2);
        end else if (tick && quiet) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assert_filt_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !tick && !code_wr) |=> $stable(filt));

    assert_hold_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !code_wr) |=> $stable(hold_q));
endmodule

// File: rtl/dip_factor.sv
// Module: edge detection on filtered levels and sticky factor flags.
// Assumes clr is a write-1-to-clear mask valid for one cycle.
module dip_factor #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] filt,
    input  logic [W-1:0] fall_sel,
    input  logic [W-1:0] quiet,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;
    logic [W-1:0] flag_q;

    assign rise  = filt & ~prev_q;
    assign fall  = ~filt & prev_q;
    assign hit   = ((fall_sel & fall) | (~fall_sel & rise)) & ~quiet;
    assign flags = flag_q;

    // Remember the previous filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= filt;
    end

    // Sticky flags: clear by mask, a new hit wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr) | hit;
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(flag_q) & ~$past(clr))) & ~flag_q) == '0));

    assert_quiet_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|quiet) |=> (((flag_q & ~$past(flag_q)) & $past(quiet)) == '0));
endmodule

// File: rtl/debounce_irq_port.sv
// Module: top of the debounced edge-interrupt input port. Holds the
// configuration registers, the read mux and the request/level outputs.
// Assumes N_BITS is a multiple of GRP_W and GRP_W >= 4 (code field + spare bit).
module debounce_irq_port
    import dip_pkg::*;
#(
    parameter int          N_BITS = 8,
    parameter int          GRP_W  = 4,
    parameter int unsigned LEN_A  = 128,
    parameter int unsigned LEN_B  = 512,
    parameter int unsigned LEN_C  = 2048,
    parameter int unsigned LEN_D  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [N_BITS-1:0] pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_BITS-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N_BITS-1:0] rd_data,
    output logic              irq_req,
    output logic [1:0]        irq_level
);
    localparam int N_GRP = N_BITS / GRP_W;
    localparam int CW    = $clog2(LEN_D + 3);

    logic [N_BITS-1:0] raw;
    logic [N_BITS-1:0] filt;
    logic [N_BITS-1:0] quiet_bits;
    logic [N_BITS-1:0] flags;
    logic [N_BITS-1:0] fall_sel_q;
    logic [N_BITS-1:0] mask_q;
    logic [1:0]        prio_q;
    logic [N_BITS-1:0] cfg_view;
    logic [N_BITS-1:0] clr;
    logic              wr_cfg;

    assign wr_cfg = wr_en && (reg_addr_e'(wr_addr) == RA_FILT);
    assign clr    = (wr_en && (reg_addr_e'(wr_addr) == RA_FLAG)) ? wr_data : '0;

    dip_sync #(.W(N_BITS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (raw)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        chk_code_t code_q;
        chk_code_t code_nxt;
        logic      code_chg;
        logic      quiet;

        assign code_nxt = wr_data[g*GRP_W +: 3];
        assign code_chg = wr_cfg && (code_nxt != code_q);

        // Group filter code register.
        always_ff @(posedge clk) begin
            if (!rst_n)      code_q <= '0;
            else if (wr_cfg) code_q <= code_nxt;
        end

        dip_filt_grp #(
            .W(GRP_W), .LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C), .LEN_D(LEN_D), .CW(CW)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (slow_tick),
            .raw      (raw[g*GRP_W +: GRP_W]),
            .code     (code_q),
            .code_wr  (code_chg),
            .code_nxt (code_nxt),
            .filt     (filt[g*GRP_W +: GRP_W]),
            .quiet    (quiet)
        );

        assign quiet_bits[g*GRP_W +: GRP_W] = {GRP_W{quiet}};
        assign cfg_view[g*GRP_W +: GRP_W]   = {{(GRP_W-3){1'b0}}, code_q};
    end

    dip_factor #(.W(N_BITS)) u_factor (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt     (filt),
        .fall_sel (fall_sel_q),
        .quiet    (quiet_bits),
        .clr      (clr),
        .flags    (flags)
    );

    // Edge-select, enable and priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_sel_q <= '0;
            mask_q     <= '0;
            prio_q     <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_EDGE: fall_sel_q <= wr_data;
                RA_MASK: mask_q     <= wr_data;
                RA_PRIO: prio_q     <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    // Combinational register read mux.
    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_EDGE:  rd_data = fall_sel_q;
            RA_MASK:  rd_data = mask_q;
            RA_FLAG:  rd_data = flags;
            RA_FILT:  rd_data = cfg_view;
            RA_PRIO:  rd_data = {{(N_BITS-2){1'b0}}, prio_q};
            RA_LEVEL: rd_data = filt;
            default:  rd_data = '0;
        endcase
    end

    assign irq_req   = (|(flags & mask_q)) && (prio_q != 2'd0);
    assign irq_level = irq_req ? prio_q : 2'd0;

    assert_prio_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q == 2'd0) |-> (!irq_req && irq_level == 2'd0));
endmodule

// File: tb/debounce_irq_port_tb.sv
module debounce_irq_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b1;
    logic [7:0] pin_in = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_req;
    logic [1:0] irq_level;

    int nchk = 0;
    int nerr = 0;
    int tick_div = 1;   // 0: tick off, 1: every cycle, n: every n-th cycle
    int cyc = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    debounce_irq_port u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pin_in(pin_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_req(irq_req), .irq_level(irq_level)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_s1, m_s2, m_filt, m_fq, m_flags, m_en, m_sel;
    logic [1:0] m_prio;
    int m_cnt[8];
    int m_hold[2];
    int m_cfg[2];

    function automatic int lim(int c);
        case (c)
            1: return 128;
            2: return 512;
            3: return 2048;
            4: return 4096;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [7:0] set_v, clr_v, nf;
        int newc[2];
        bit chg[2];
        bit e;
        int g, L;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_filt = 0; m_fq = 0; m_flags = 0;
            m_en = 0; m_sel = 0; m_prio = 0;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
            for (int k = 0; k < 2; k++) begin m_hold[k] = 0; m_cfg[k] = 0; end
        end else begin
            for (int k = 0; k < 2; k++) begin
                newc[k] = int'(wr_data[k*4 +: 3]);
                chg[k]  = wr_en && wr_addr == 3'd3 && newc[k] != m_cfg[k];
            end
            for (int i = 0; i < 8; i++) begin
                g = i / 4;
                e = m_sel[i] ? (m_fq[i] && !m_filt[i]) : (m_filt[i] && !m_fq[i]);
                set_v[i] = e && (m_hold[g] == 0);
            end
            clr_v = (wr_en && wr_addr == 3'd2) ? wr_data : 8'h00;
            nf = m_filt;
            for (int i = 0; i < 8; i++) begin
                g = i / 4;
                L = lim(m_cfg[g]);
                if (chg[g]) m_cnt[i] = 0;
                else if (L == 0) nf[i] = m_s2[i];
                else if (m_s2[i] == m_filt[i]) m_cnt[i] = 0;
                else if (slow_tick) begin
                    if (m_cnt[i] == L - 1) begin nf[i] = m_s2[i]; m_cnt[i] = 0; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            m_fq = m_filt; m_filt = nf; m_s2 = m_s1; m_s1 = pin_in;
            for (int k = 0; k < 2; k++) begin
                if (chg[k]) m_hold[k] = lim(newc[k]) + 2;
                else if (slow_tick && m_hold[k] > 0) m_hold[k] = m_hold[k] - 1;
            end
            m_flags = (m_flags & ~clr_v) | set_v;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_sel = wr_data;
                    3'd1: m_en = wr_data;
                    3'd3: begin m_cfg[0] = newc[0]; m_cfg[1] = newc[1]; end
                    3'd4: m_prio = wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] m_rd(logic [2:0] a);
        case (a)
            3'd0: return m_sel;
            3'd1: return m_en;
            3'd2: return m_flags;
            3'd3: return {1'b0, 3'(m_cfg[1]), 1'b0, 3'(m_cfg[0])};
            3'd4: return {6'b0, m_prio};
            3'd5: return m_filt;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string addr_tag(logic [2:0] a);
        case (a)
            3'd0: return "R5";
            3'd1: return "R7";
            3'd2: return "R6";
            3'd3: return "R3";
            3'd4: return "R8";
            3'd5: return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic mreq;
            mreq = (|(m_flags & m_en)) && (m_prio != 0);
            check("R7 irq_req", int'(irq_req), int'(mreq));
            check("R8 irq_level", int'(irq_level), mreq ? int'(m_prio) : 0);
            check({addr_tag(rd_addr), " rd_data"}, int'(rd_data), int'(m_rd(rd_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
        if (tick_div == 0) slow_tick = 1'b0;
        else slow_tick = (cyc % tick_div) == 0;
        rd_addr = rd_addr + 3'd1;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, logic [7:0] mask, logic [7:0] exp, string tag);
        rd_addr = a;
        #1;
        check(tag, int'(rd_data & mask), int'(exp));
    endtask

    initial begin : watchdog
        #(200000 * 10);
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin : stim
        logic [15:0] lf;
        lf = 16'hACE1;
        steps(4);
        rst_n = 1'b1;
        step();
        cmp_on = 1;

        // R1 / R11: reset state and unused addresses
        for (int a = 0; a < 8; a++) peek(3'(a), 8'hFF, 8'h00, "R1 reset register");
        check("R1 irq_req after reset", int'(irq_req), 0);
        check("R1 irq_level after reset", int'(irq_level), 0);

        wr(3'd1, 8'hFF);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'hF0);
        wr(3'd4, 8'hFE);
        peek(3'd4, 8'hFF, 8'h02, "R11 unused priority bits read 0");
        wr(3'd3, 8'h88);
        peek(3'd3, 8'hFF, 8'h00, "R11 unused code bits read 0");
        steps(4);

        // R2: synchronizer latency with bypass
        pin_in = 8'h01;
        steps(2);
        peek(3'd5, 8'h01, 8'h00, "R2 level not yet through sync");
        step();
        peek(3'd5, 8'h01, 8'h01, "R2 level after three edges");
        step();
        peek(3'd2, 8'h01, 8'h01, "R5 rising edge sets flag 0");
        check("R7 request with enabled flag", int'(irq_req), 1);
        check("R8 level equals priority", int'(irq_level), 2);

        // Random patterns with bypass filters
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[0]) pin_in = lf[15:8];
            step();
        end
        pin_in = 8'h00;
        steps(6);

        // R6: write-0 no effect, write-1 clears
        wr(3'd2, 8'h00);
        peek(3'd2, 8'hFF, 8'hFF, "R6 write 0 keeps flags");
        wr(3'd2, 8'hFF);
        peek(3'd2, 8'hFF, 8'h00, "R6 write 1 clears flags");

        // R7: masked flags do not request
        wr(3'd1, 8'h00);
        pin_in = 8'h02;
        steps(5);
        peek(3'd2, 8'h02, 8'h02, "R7 flag sets while disabled");
        check("R7 no request when masked", int'(irq_req), 0);
        wr(3'd1, 8'h02);
        wr(3'd4, 8'h00);
        check("R8 priority 0 gives no request", int'(irq_req), 0);
        wr(3'd4, 8'h03);
        check("R8 level 3 request", int'(irq_level), 3);
        pin_in = 8'h00;
        steps(5);
        wr(3'd2, 8'hFF);

        // R3: lengths 128 (low group) and 4096 (high group)
        wr(3'd3, 8'h41);
        steps(4200);
        pin_in = 8'h02;
        steps(129);
        peek(3'd5, 8'h02, 8'h00, "R3 128-tick filter not yet");
        step();
        peek(3'd5, 8'h02, 8'h02, "R3 128-tick filter accepted");
        pin_in = 8'h42;
        steps(4097);
        peek(3'd5, 8'h40, 8'h00, "R3 4096-tick filter not yet");
        step();
        peek(3'd5, 8'h40, 8'h40, "R3 4096-tick filter accepted");

        // R4: short pulse ignored
        pin_in = 8'h46;
        steps(60);
        pin_in = 8'h42;
        steps(300);
        peek(3'd5, 8'h04, 8'h00, "R4 short pulse ignored");

        // R10: no ticks, no progress
        tick_div = 0;
        pin_in = 8'h4A;
        steps(500);
        peek(3'd5, 8'h08, 8'h00, "R10 no change without ticks");
        tick_div = 1;
        steps(140);
        peek(3'd5, 8'h08, 8'h08, "R10 change after ticks resume");

        // R9: code change mid-transition is held off
        wr(3'd3, 8'h44);
        steps(4200);
        wr(3'd2, 8'hFF);
        pin_in = 8'h4B;
        steps(300);
        wr(3'd3, 8'h41);
        steps(200);
        peek(3'd5, 8'h01, 8'h01, "R9 level accepted under new code");
        peek(3'd2, 8'h01, 8'h00, "R9 flag held off after code change");

        // R9: switch to bypass mid-transition
        pin_in = 8'h4F;
        steps(50);
        wr(3'd3, 8'h40);
        steps(10);
        peek(3'd5, 8'h04, 8'h04, "R9 bypass passes level");
        peek(3'd2, 8'h04, 8'h00, "R9 bypass switch held off");

        // Sparse ticks with random patterns
        wr(3'd3, 8'h51);
        wr(3'd0, 8'h5A);
        tick_div = 3;
        for (int i = 0; i < 6000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[3:0] == 4'h0) pin_in = lf[15:8];
            if (i % 997 == 0) wr(3'd2, lf[7:0]);
            step();
        end

        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule